// File: doc/BRIEF.md
# Time-Multiplexed Spiking Neuron Inference Engine

This block evaluates a set of logical spiking neurons on one shared arithmetic datapath. A single-cycle round pulse starts an evaluation round. At that edge the engine captures the vector of axon spike bits, which every logical neuron in the round shares. It then visits the neurons in index order. Each neuron gets a fixed slot of N+4 clocks:

- N clocks walk the axons and add the weight of every axon whose spike bit is set.
- One clock adds the neuron's bias.
- One clock adds the potential stored for that neuron by the previous round.
- One clock decides whether the neuron fires.
- One clock writes the new potential back and, when the neuron fired, emits an address event that names it.

A final idle slot of the same length closes the round. That slot leaves the downstream learning unit time to finish work on the last neuron.

Weights, bias, threshold, mode, the random-range exponent and the stored potential all sit in memories outside the block. The engine presents a neuron index and an axon index, and reads the data back in the same cycle. Each neuron has one of four modes:

- plain integrate-and-fire;
- stochastic integrate-and-fire, where a pseudo-random offset is added to the threshold;
- spiking ReLU, which keeps the surplus above the threshold after it fires;
- learning-enabled, which fires like plain integrate-and-fire.

For a learning-enabled neuron, every weight read during its slot is also pushed into a small first-in first-out store. A learning unit drains that store while the next neuron is evaluated.

Top module: `tmux_neuron_core`

## Requirements
- R1: When the engine is idle, a high `sync_i` starts a round at that edge. `busy_o` then stays high for exactly (M+1)*(N+4) cycles. A `sync_i` pulse seen while `busy_o` is high is ignored.
- R2: The axon spike vector is captured at the edge that starts the round. Changes on `axon_spk_i` after that edge have no effect on the round.
- R3: Cycle c = 0 is the first cycle after the starting edge. Neuron n reads the weight of axon k in cycle n*(N+4)+k, with `wt_rd_o`=1, `nrn_idx_o`=n and `wt_axon_o`=k. Its potential write-back occurs only in cycle n*(N+4)+N+3, and lasts one cycle.
- R4: The integrated value v is built in this order: the weights of axons whose spike bit is 1, taken in ascending axon order, then the bias, then the old potential. After each addition the result is saturated to the signed PW-bit range.
- R5: In mode code 0 (integrate-and-fire) and mode code 3 (learning-enabled), the neuron fires when v >= threshold. The new potential is 0 after a fire and v otherwise.
- R6: In mode code 1 (stochastic), the threshold is thr + (L & (2^rexp - 1)). L is a 16-bit shift register with reset value `LFSR_SEED`. L is used before it steps. L steps once per stochastic neuron evaluation, to {L[14:0], L[15]^L[13]^L[12]^L[10]}, and at no other time.
- R7: In mode code 2 (ReLU), a fire leaves the potential at v - thr, saturated to PW bits. Without a fire the potential stays v, so a large charge is released over several rounds.
- R8: `pot_we_o` is high in each neuron's write-back cycle, carrying the new potential on `pot_wd_o`. `spk_valid_o` is high in that same cycle, with `spk_nrn_o`=n, only when the neuron fired. Neither output is high during the closing slot.
- R9: For a learning-enabled neuron, all N weights are pushed in axon order during its weight-read cycles. Other modes push nothing. `lrn_wt_o` shows the oldest entry whenever `lrn_valid_o` is high, and `lrn_pop_i` removes it.
- R10: When the store holds FIFO_DEPTH entries, further pushes are dropped, and the stored entries and their order are kept.
- R11: After reset the engine is idle: `busy_o`, `pot_we_o`, `spk_valid_o` and `lrn_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Round start pulse |
| axon_spk_i | input | N | Axon spike bits for the next round |
| busy_o | output | 1 | Round in progress |
| nrn_idx_o | output | IW | Logical neuron under evaluation (configuration, weight and potential address) |
| wt_axon_o | output | AXW | Axon index of the weight being read |
| wt_rd_o | output | 1 | Weight read strobe |
| wt_data_i | input | WW | Signed weight for (nrn_idx_o, wt_axon_o) |
| cfg_mode_i | input | 2 | Mode code of the current neuron |
| cfg_bias_i | input | PW | Signed bias |
| cfg_thr_i | input | PW | Signed threshold (lower bound in stochastic mode) |
| cfg_rexp_i | input | RXW | Width of the random threshold range, as a power of two |
| pot_rd_i | input | PW | Stored potential of the current neuron |
| pot_we_o | output | 1 | Potential write strobe |
| pot_wd_o | output | PW | New potential |
| spk_valid_o | output | 1 | Address event valid |
| spk_nrn_o | output | IW | Index of the neuron that fired |
| lrn_valid_o | output | 1 | Weight store not empty |
| lrn_wt_o | output | WW | Oldest stored weight |
| lrn_pop_i | input | 1 | Remove the oldest stored weight |

## Verification
The bench builds the engine with four neurons, eight axons, 8-bit weights and a 10-bit potential. With these values, eight full-scale weights overflow the potential partway through the axon walk, so saturation at each step is observable. It also lets a ReLU neuron discharge over a few rounds. A 16-entry weight store fills after two learning neurons, which brings the drop rule within reach of a single round. Short rounds of 60 cycles allow many random configurations, including late changes to the spike input and a second sync pulse mid-round. Every write-back is compared with an arithmetic model that carries its own copy of the shift register.

// File: rtl/tnc_pkg.sv
package tnc_pkg;

  typedef enum logic [1:0] {
    MODE_IF    = 2'd0,
    MODE_SIF   = 2'd1,
    MODE_RELU  = 2'd2,
    MODE_LEARN = 2'd3
  } tnc_mode_e;

  localparam int RNG_W = 16;

  // one step of the threshold noise source
  function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
    return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/tnc_sequencer.sv
module tnc_sequencer #(
  parameter int M = 16,
  parameter int N = 16,
  localparam int SW = $clog2(M + 1),
  localparam int TW = $clog2(N + 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic          busy_o,
  output logic          start_o,
  output logic [SW-1:0] slot_o,
  output logic [TW-1:0] step_o,
  output logic          ph_acc_o,
  output logic          ph_bias_o,
  output logic          ph_pot_o,
  output logic          ph_cmp_o,
  output logic          ph_wb_o
);

  localparam logic [TW-1:0] STEP_BIAS = TW'(N);
  localparam logic [TW-1:0] STEP_POT  = TW'(N + 1);
  localparam logic [TW-1:0] STEP_CMP  = TW'(N + 2);
  localparam logic [TW-1:0] STEP_WB   = TW'(N + 3);
  localparam logic [SW-1:0] SLOT_TAIL = SW'(M);

  logic          busy_q;
  logic [SW-1:0] slot_q;
  logic [TW-1:0] step_q;
  logic          in_nrn;

  assign start_o = !busy_q && sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      step_q <= '0;
    end else if (!busy_q) begin
      if (sync_i) begin
        busy_q <= 1'b1;
        slot_q <= '0;
        step_q <= '0;
      end
    end else if (step_q == STEP_WB) begin
      step_q <= '0;
      if (slot_q == SLOT_TAIL) busy_q <= 1'b0;
      else                     slot_q <= slot_q + 1'b1;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  assign in_nrn    = busy_q && (slot_q != SLOT_TAIL);
  assign ph_acc_o  = in_nrn && (step_q < STEP_BIAS);
  assign ph_bias_o = in_nrn && (step_q == STEP_BIAS);
  assign ph_pot_o  = in_nrn && (step_q == STEP_POT);
  assign ph_cmp_o  = in_nrn && (step_q == STEP_CMP);
  assign ph_wb_o   = in_nrn && (step_q == STEP_WB);
  assign busy_o    = busy_q;
  assign slot_o    = slot_q;
  assign step_o    = step_q;

endmodule

// File: rtl/tnc_threshold_rng.sv
module tnc_threshold_rng #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv_i,
  output logic [15:0] rnd_o
);

  logic [15:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEED;
    else if (adv_i) state_q <= tnc_pkg::rng_next(state_q);
  end

  assign rnd_o = state_q;

endmodule

// File: rtl/tnc_integrator.sv
module tnc_integrator #(
  parameter int N   = 16,
  parameter int WW  = 8,
  parameter int PW  = 16,
  parameter int RXW = 4,
  localparam int TW  = $clog2(N + 4),
  localparam int AXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [N-1:0]         spk_vec_i,
  input  logic [TW-1:0]        step_i,
  input  logic                 ph_acc_i,
  input  logic                 ph_bias_i,
  input  logic                 ph_pot_i,
  input  logic                 ph_cmp_i,
  input  logic                 ph_wb_i,
  input  logic signed [WW-1:0] wt_i,
  input  logic signed [PW-1:0] bias_i,
  input  logic signed [PW-1:0] pot_i,
  input  logic signed [PW-1:0] thr_i,
  input  logic [RXW-1:0]       rexp_i,
  input  logic [1:0]           mode_i,
  input  logic [15:0]          rnd_i,
  output logic                 rng_adv_o,
  output logic                 fire_o,
  output logic signed [PW-1:0] newpot_o
);

  import tnc_pkg::*;

  localparam int XW  = PW + 2;
  localparam int TEW = PW + RNG_W + 1;
  localparam int MAX_I = (1 << (PW - 1)) - 1;
  localparam int MIN_I = -(1 << (PW - 1));
  localparam logic signed [XW-1:0] MAXV = XW'(MAX_I);
  localparam logic signed [XW-1:0] MINV = XW'(MIN_I);

  function automatic logic signed [PW-1:0] clamp(input logic signed [XW-1:0] x);
    if (x > MAXV) return MAXV[PW-1:0];
    if (x < MINV) return MINV[PW-1:0];
    return x[PW-1:0];
  endfunction

  function automatic logic signed [PW-1:0] sat_sum(input logic signed [PW-1:0] a,
                                                   input logic signed [PW-1:0] b);
    return clamp(XW'(a) + XW'(b));
  endfunction

  function automatic logic signed [PW-1:0] sat_diff(input logic signed [PW-1:0] a,
                                                    input logic signed [PW-1:0] b);
    return clamp(XW'(a) - XW'(b));
  endfunction

  logic [N-1:0]         spk_buf_q;
  logic signed [PW-1:0] acc_q;
  logic                 fire_q;
  logic signed [PW-1:0] newpot_q;

  tnc_mode_e             mode;
  logic [15:0]           range_mask;
  logic signed [TEW-1:0] thr_eff;
  logic                  fire_c;
  logic signed [PW-1:0]  newpot_c;
  logic                  cur_spk;

  assign mode       = tnc_mode_e'(mode_i);
  assign cur_spk    = spk_buf_q[step_i[AXW-1:0]];
  assign range_mask = ~(16'hFFFF << rexp_i);

  always_comb begin
    thr_eff = TEW'(thr_i);
    if (mode == MODE_SIF)
      thr_eff = TEW'(thr_i) + TEW'($signed({1'b0, rnd_i & range_mask}));
    fire_c = (TEW'(acc_q) >= thr_eff);
    if (mode == MODE_RELU) newpot_c = fire_c ? sat_diff(acc_q, thr_i) : acc_q;
    else                   newpot_c = fire_c ? '0 : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_buf_q <= '0;
      acc_q     <= '0;
      fire_q    <= 1'b0;
      newpot_q  <= '0;
    end else begin
      if (start_i) begin
        spk_buf_q <= spk_vec_i;
        acc_q     <= '0;
      end
      if (ph_acc_i && cur_spk) acc_q <= sat_sum(acc_q, PW'(wt_i));
      if (ph_bias_i)           acc_q <= sat_sum(acc_q, bias_i);
      if (ph_pot_i)            acc_q <= sat_sum(acc_q, pot_i);
      if (ph_cmp_i) begin
        fire_q   <= fire_c;
        newpot_q <= newpot_c;
      end
      if (ph_wb_i) acc_q <= '0;
    end
  end

  assign rng_adv_o = ph_cmp_i && (mode == MODE_SIF);
  assign fire_o    = fire_q;
  assign newpot_o  = newpot_q;

endmodule

// File: rtl/tnc_weight_fifo.sv
module tnc_weight_fifo #(
  parameter int WW    = 8,
  parameter int DEPTH = 32,
  localparam int PTW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [WW-1:0] din_i,
  input  logic          pop_i,
  output logic [WW-1:0] dout_o,
  output logic          valid_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);

  localparam logic [PTW-1:0] LAST = PTW'(DEPTH - 1);

  logic [WW-1:0]  mem_q [DEPTH];
  logic [PTW-1:0] wr_q, rd_q;
  logic [CW-1:0]  cnt_q;
  logic           push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/tmux_neuron_core.sv
module tmux_neuron_core #(
  parameter int          M          = 16,
  parameter int          N          = 16,
  parameter int          WW         = 8,
  parameter int          PW         = 16,
  parameter int          RXW        = 4,
  parameter int          FIFO_DEPTH = 2 * N,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  localparam int IW  = (M > 1) ? $clog2(M) : 1,
  localparam int AXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_i,
  input  logic [N-1:0]   axon_spk_i,
  output logic           busy_o,
  output logic [IW-1:0]  nrn_idx_o,
  output logic [AXW-1:0] wt_axon_o,
  output logic           wt_rd_o,
  input  logic [WW-1:0]  wt_data_i,
  input  logic [1:0]     cfg_mode_i,
  input  logic [PW-1:0]  cfg_bias_i,
  input  logic [PW-1:0]  cfg_thr_i,
  input  logic [RXW-1:0] cfg_rexp_i,
  input  logic [PW-1:0]  pot_rd_i,
  output logic           pot_we_o,
  output logic [PW-1:0]  pot_wd_o,
  output logic           spk_valid_o,
  output logic [IW-1:0]  spk_nrn_o,
  output logic           lrn_valid_o,
  output logic [WW-1:0]  lrn_wt_o,
  input  logic           lrn_pop_i
);

  localparam int SW = $clog2(M + 1);
  localparam int TW = $clog2(N + 4);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  // named internal events, also observed by the checker
  logic          start_w;
  logic [SW-1:0] slot_w;
  logic [TW-1:0] step_w;
  logic          ph_acc_w, ph_bias_w, ph_pot_w, ph_cmp_w, ph_wb_w;
  logic          rng_adv_w;
  logic [15:0]   rnd_w;
  logic          fire_w;
  logic [PW-1:0] newpot_w;
  logic          fifo_push_w;
  logic          fifo_full_w;
  logic [CW-1:0] fifo_cnt_w;

  tnc_sequencer #(.M(M), .N(N)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .busy_o    (busy_o),
    .start_o   (start_w),
    .slot_o    (slot_w),
    .step_o    (step_w),
    .ph_acc_o  (ph_acc_w),
    .ph_bias_o (ph_bias_w),
    .ph_pot_o  (ph_pot_w),
    .ph_cmp_o  (ph_cmp_w),
    .ph_wb_o   (ph_wb_w)
  );

  tnc_threshold_rng #(.SEED(LFSR_SEED)) rng_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (rng_adv_w),
    .rnd_o (rnd_w)
  );

  tnc_integrator #(.N(N), .WW(WW), .PW(PW), .RXW(RXW)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .spk_vec_i (axon_spk_i),
    .step_i    (step_w),
    .ph_acc_i  (ph_acc_w),
    .ph_bias_i (ph_bias_w),
    .ph_pot_i  (ph_pot_w),
    .ph_cmp_i  (ph_cmp_w),
    .ph_wb_i   (ph_wb_w),
    .wt_i      ($signed(wt_data_i)),
    .bias_i    ($signed(cfg_bias_i)),
    .pot_i     ($signed(pot_rd_i)),
    .thr_i     ($signed(cfg_thr_i)),
    .rexp_i    (cfg_rexp_i),
    .mode_i    (cfg_mode_i),
    .rnd_i     (rnd_w),
    .rng_adv_o (rng_adv_w),
    .fire_o    (fire_w),
    .newpot_o  (newpot_w)
  );

  assign fifo_push_w = ph_acc_w && (tnc_pkg::tnc_mode_e'(cfg_mode_i) == tnc_pkg::MODE_LEARN);

  tnc_weight_fifo #(.WW(WW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (fifo_push_w),
    .din_i   (wt_data_i),
    .pop_i   (lrn_pop_i),
    .dout_o  (lrn_wt_o),
    .valid_o (lrn_valid_o),
    .full_o  (fifo_full_w),
    .count_o (fifo_cnt_w)
  );

  assign nrn_idx_o   = slot_w[IW-1:0];
  assign wt_axon_o   = step_w[AXW-1:0];
  assign wt_rd_o     = ph_acc_w;
  assign pot_we_o    = ph_wb_w;
  assign pot_wd_o    = newpot_w;
  assign spk_valid_o = ph_wb_w && fire_w;
  assign spk_nrn_o   = slot_w[IW-1:0];

endmodule

// File: rtl/tnc_core_chk.sv
module tnc_core_chk #(
  parameter int AXW = 4,
  parameter int CW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sync_i,
  input logic           busy_o,
  input logic           pot_we_o,
  input logic           spk_valid_o,
  input logic           wt_rd_o,
  input logic [AXW-1:0] wt_axon_o,
  input logic           fifo_push_w,
  input logic           fifo_full_w,
  input logic           lrn_pop_i,
  input logic [CW-1:0]  fifo_cnt_w
);

  // R1
  round_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(sync_i));

  // R8
  event_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spk_valid_o |-> pot_we_o);

  // R8
  wb_in_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pot_we_o |-> busy_o);

  // R3
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pot_we_o |=> !pot_we_o);

  // R3
  axon_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_rd_o && wt_axon_o != '0) |-> ($past(wt_rd_o) && wt_axon_o == $past(wt_axon_o) + AXW'(1)));

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push_w && fifo_full_w && !lrn_pop_i) |=> $stable(fifo_cnt_w));

endmodule

bind tmux_neuron_core tnc_core_chk #(.AXW(AXW), .CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_i      (sync_i),
  .busy_o      (busy_o),
  .pot_we_o    (pot_we_o),
  .spk_valid_o (spk_valid_o),
  .wt_rd_o     (wt_rd_o),
  .wt_axon_o   (wt_axon_o),
  .fifo_push_w (fifo_push_w),
  .fifo_full_w (fifo_full_w),
  .lrn_pop_i   (lrn_pop_i),
  .fifo_cnt_w  (fifo_cnt_w)
);

// File: tb/tmux_neuron_core_tb_top.sv
`timescale 1ns/1ps
module tmux_neuron_core_tb_top;

  localparam int M   = 4;
  localparam int N   = 8;
  localparam int WW  = 8;
  localparam int PW  = 10;
  localparam int RXW = 3;
  localparam int FD  = 16;
  localparam int IW  = 2;
  localparam int AXW = 3;
  localparam int SLOT = N + 4;
  localparam int TOT  = (M + 1) * SLOT;
  localparam int PMAX = (1 << (PW - 1)) - 1;
  localparam int PMIN = -(1 << (PW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           sync_i = 1'b0;
  logic [N-1:0]   axon_spk_i = '0;
  logic           busy_o;
  logic [IW-1:0]  nrn_idx_o;
  logic [AXW-1:0] wt_axon_o;
  logic           wt_rd_o;
  logic [WW-1:0]  wt_data_i;
  logic [1:0]     cfg_mode_i;
  logic [PW-1:0]  cfg_bias_i, cfg_thr_i, pot_rd_i;
  logic [RXW-1:0] cfg_rexp_i;
  logic           pot_we_o;
  logic [PW-1:0]  pot_wd_o;
  logic           spk_valid_o;
  logic [IW-1:0]  spk_nrn_o;
  logic           lrn_valid_o;
  logic [WW-1:0]  lrn_wt_o;
  logic           lrn_pop_i = 1'b0;

  // bench-side memories
  logic signed [WW-1:0] w_mem [M][N];
  logic signed [PW-1:0] bias_mem [M];
  logic signed [PW-1:0] thr_mem [M];
  logic signed [PW-1:0] pot_mem [M];
  logic [1:0]           mode_mem [M];
  logic [RXW-1:0]       rexp_mem [M];

  assign wt_data_i  = w_mem[nrn_idx_o][wt_axon_o];
  assign cfg_mode_i = mode_mem[nrn_idx_o];
  assign cfg_bias_i = bias_mem[nrn_idx_o];
  assign cfg_thr_i  = thr_mem[nrn_idx_o];
  assign cfg_rexp_i = rexp_mem[nrn_idx_o];
  assign pot_rd_i   = pot_mem[nrn_idx_o];

  always @(posedge clk) if (pot_we_o) pot_mem[nrn_idx_o] <= pot_wd_o;

  tmux_neuron_core #(.M(M), .N(N), .WW(WW), .PW(PW), .RXW(RXW),
                     .FIFO_DEPTH(FD), .LFSR_SEED(16'hACE1)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  int unsigned lcg = 32'h1234_5678;

  // model state
  int          m_pot [M];
  int          e_pot [M];
  bit          e_fire [M];
  logic [15:0] m_rng = 16'hACE1;
  int          q [FD];
  int          qn;

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int rnd(input int range);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 8) % range);
  endfunction

  function automatic int sat(input int x);
    return (x > PMAX) ? PMAX : (x < PMIN) ? PMIN : x;
  endfunction

  task automatic predict(input logic [N-1:0] spk);
    qn = 0;
    for (int n = 0; n < M; n++) begin
      int v, th;
      bit f;
      v = 0;
      for (int k = 0; k < N; k++) begin
        if (spk[k]) v = sat(v + int'(w_mem[n][k]));
        if (mode_mem[n] == 2'd3 && qn < FD) begin
          q[qn] = int'(w_mem[n][k]);
          qn++;
        end
      end
      v = sat(v + int'(bias_mem[n]));
      v = sat(v + m_pot[n]);
      th = int'(thr_mem[n]);
      if (mode_mem[n] == 2'd1) begin
        th = th + int'(m_rng & 16'((1 << rexp_mem[n]) - 1));
        m_rng = {m_rng[14:0], ^(m_rng & 16'hB400)};
      end
      f = (v >= th);
      if (mode_mem[n] == 2'd2) e_pot[n] = f ? sat(v - th) : v;
      else                     e_pot[n] = f ? 0 : v;
      e_fire[n] = f;
      m_pot[n]  = e_pot[n];
    end
  endtask

  task automatic drain();
    int got = 0;
    while (lrn_valid_o && got < 2 * FD) begin
      if (got < qn)
        chk(int'($signed(lrn_wt_o)) == q[got],
            $sformatf("R9 entry %0d got %0d exp %0d", got, $signed(lrn_wt_o), q[got]));
      lrn_pop_i = 1'b1;
      @(negedge clk);
      got++;
    end
    lrn_pop_i = 1'b0;
    chk(got == qn, $sformatf("%s stored count got %0d exp %0d",
                             (qn == FD) ? "R10" : "R9", got, qn));
  endtask

  task automatic run_round(input logic [N-1:0] spk, input logic [N-1:0] late, input bit dbl);
    bit sched_err = 0;
    bit busy_err = 0;
    predict(spk);
    @(negedge clk);
    axon_spk_i = spk;
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    axon_spk_i = late;   // R2: must not matter
    for (int c = 0; c < TOT; c++) begin
      int s, t;
      s = c / SLOT;
      t = c % SLOT;
      sync_i = dbl && (c == 5);   // R1: ignored while busy
      if (!busy_o) busy_err = 1;
      if (s < M && t == N + 3) begin
        string tag;
        tag = (mode_mem[s] == 2'd1) ? "R6" : (mode_mem[s] == 2'd2) ? "R7" : "R5";
        chk(pot_we_o && int'($signed(pot_wd_o)) == e_pot[s] && spk_valid_o == e_fire[s]
            && (!spk_valid_o || int'(spk_nrn_o) == s),
            $sformatf("%s R4 R8 neuron %0d: we=%0b wd=%0d spk=%0b exp wd=%0d spk=%0b",
                      tag, s, pot_we_o, $signed(pot_wd_o), spk_valid_o, e_pot[s], e_fire[s]));
      end else begin
        if (pot_we_o || spk_valid_o) sched_err = 1;
        if (s < M && t < N &&
            !(wt_rd_o && int'(wt_axon_o) == t && int'(nrn_idx_o) == s)) sched_err = 1;
        if (s == M && wt_rd_o) sched_err = 1;
      end
      @(negedge clk);
    end
    sync_i = 1'b0;
    chk(!sched_err, $sformatf("R3 read/write schedule error got 1 exp 0"));
    chk(!busy_err && !busy_o,
        $sformatf("R1 busy window: early drop=%0b busy at end=%0b exp 0/0", busy_err, busy_o));
    drain();
  endtask

  task automatic rand_config();
    for (int n = 0; n < M; n++) begin
      for (int k = 0; k < N; k++) w_mem[n][k] = WW'(rnd(256) - 128);
      bias_mem[n] = PW'(rnd(64) - 32);
      thr_mem[n]  = PW'(rnd(300) - 20);
      mode_mem[n] = 2'(rnd(4));
      rexp_mem[n] = RXW'(rnd(8));
    end
  endtask

  initial begin
    for (int n = 0; n < M; n++) begin
      pot_mem[n] = '0;
      m_pot[n] = 0;
      for (int k = 0; k < N; k++) w_mem[n][k] = '0;
      bias_mem[n] = '0; thr_mem[n] = '0; mode_mem[n] = 2'd0; rexp_mem[n] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!busy_o && !pot_we_o && !spk_valid_o && !lrn_valid_o,
        $sformatf("R11 in reset busy=%0b we=%0b spk=%0b lv=%0b exp 0", busy_o, pot_we_o, spk_valid_o, lrn_valid_o));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !pot_we_o && !spk_valid_o && !lrn_valid_o,
        $sformatf("R11 after reset busy=%0b we=%0b spk=%0b lv=%0b exp 0", busy_o, pot_we_o, spk_valid_o, lrn_valid_o));

    // directed: saturation, ReLU burst, stochastic, learning
    for (int k = 0; k < N; k++) begin
      w_mem[0][k] = 8'sd127;
      w_mem[1][k] = 8'sd50;
      w_mem[2][k] = 8'sd2;
      w_mem[3][k] = WW'(k - 4);
    end
    bias_mem[0] = -10'sd100; thr_mem[0] = 10'sd400; mode_mem[0] = 2'd0;   // R4 saturates mid-walk
    bias_mem[1] = 10'sd0;    thr_mem[1] = 10'sd100; mode_mem[1] = 2'd2;   // R7 burst
    bias_mem[2] = 10'sd1;    thr_mem[2] = 10'sd10;  mode_mem[2] = 2'd1; rexp_mem[2] = 3'd3;  // R6
    bias_mem[3] = 10'sd0;    thr_mem[3] = 10'sd5;   mode_mem[3] = 2'd3;   // R9
    run_round(8'hFF, 8'h00, 1'b0);
    for (int r = 0; r < 4; r++) run_round(8'h00, 8'hFF, r[0]);   // R7 discharge, R2, R1

    // R10: every neuron learning, 32 pushes into 16 entries
    for (int n = 0; n < M; n++) mode_mem[n] = 2'd3;
    run_round(8'hA5, 8'h5A, 1'b0);

    // random sweep
    for (int cfg = 0; cfg < 8; cfg++) begin
      rand_config();
      for (int r = 0; r < 8; r++)
        run_round(N'(rnd(256)), N'(rnd(256)), (rnd(3) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule